// File: doc/BRIEF.md
# Receive Character Queue with Idle Timeout

This block sits between a serial deserializer and a host register interface. It queues received characters together with their parity, framing and break flags, and it raises the receive-side status the host polls: data available, overrun, a sticky summary of flagged characters, a fill-level trigger and an idle timeout. It also drives an active-low receive-ready strobe for a DMA engine. The queue holds up to 16 characters when queue mode is on. When queue mode is off it holds a single character.

The host pops the oldest character with a data-read strobe and acknowledges error status with a status-read strobe. The deserializer signals each completed character with a one-cycle push and flags, a pulse at the middle of each stop bit, and a one-cycle tick per bit time.

The block has two state machines. The timeout tracker `rxq_timeout` has the states TO_IDLE, TO_RUN and TO_FIRED:
- TO_IDLE→TO_RUN when the queue holds data.
- TO_RUN→TO_FIRED when the bit-time count reaches the limit.
- TO_RUN or TO_FIRED→TO_RUN (count restarted) on a stop-bit-middle pulse or a data read.
- Any state→TO_IDLE when the queue is empty, queue mode is off, or a flush occurs.

The ready strobe machine `rxq_rdy` has the states RDY_OFF and RDY_ON:
- RDY_OFF→RDY_ON when the mode-dependent condition holds.
- RDY_ON→RDY_OFF when the queue is empty.

Top module: `rx_fifo_tmo`

## Requirements
- R1: `trig_hit_o` is high while the stored count is at or above a level and low below it. In queue mode the level comes from `trig_sel_i`: 00→1, 01→4, 10→8, 11→14. With queue mode off the level is 1.
- R2: `data_ready_o` rises in the cycle after a character is accepted and falls in the cycle after the last stored character is popped.
- R3: Characters leave in arrival order. `head_data_o` and the three head flags show the oldest stored entry, and they read as zero while the queue is empty.
- R4: A push that arrives while the queue is full is dropped and sets `overrun_o`. `overrun_o` clears on a status read (`rd_lsr_i`) unless another drop happens in the same cycle.
- R5: With `fifo_en_i` low the queue holds one character, and a second push before a read is an overrun.
- R6: The timeout fires after 4×W+12 bit ticks, where W is the word length (5 + `wlen_i`; `wlen_i` 00→5 … 11→8). This gives 32, 36, 40 or 44 ticks.
- R7: The timeout count restarts on `stop_mid_i` and on `rd_data_i`. A restart also drops an active timeout. No timeout is raised while the queue is empty or with queue mode off.
- R8: A one-cycle `fifo_clr_i` pulse empties the queue and resets its pointers. Any change of `fifo_en_i` does the same. A push in a flush cycle is discarded and causes no overrun.
- R9: Mode 0 is `dma_mode_i` low or queue mode off. In mode 0, `rxrdy_n_o` goes low one cycle after the queue holds data and high one cycle after it empties.
- R10: Mode 1 is `dma_mode_i` high with queue mode on. In mode 1, `rxrdy_n_o` goes low once the trigger level is reached or the timeout fires. It stays low until the queue is empty, even when the count falls below the level.
- R11: In queue mode, `fifo_err_o` sets when a character with any flag is stored. It clears on a status read, or when no flagged entry remains stored. It is always 0 with queue mode off.
- R12: After reset the queue is empty, all flags are 0 and `rxrdy_n_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push_i | input | 1 | Completed character strobe |
| push_data_i | input | 8 | Character value |
| push_par_err_i | input | 1 | Parity flag of pushed character |
| push_frm_err_i | input | 1 | Framing flag of pushed character |
| push_brk_i | input | 1 | Break flag of pushed character |
| stop_mid_i | input | 1 | Pulse at middle of a received stop bit |
| bit_tick_i | input | 1 | One pulse per bit time |
| rd_data_i | input | 1 | Host data read (pops head) |
| rd_lsr_i | input | 1 | Host status read |
| fifo_en_i | input | 1 | Queue mode enable |
| fifo_clr_i | input | 1 | Flush pulse |
| trig_sel_i | input | 2 | Trigger level select |
| dma_mode_i | input | 1 | Ready-strobe mode select |
| wlen_i | input | 2 | Word length code |
| head_data_o | output | 8 | Oldest character |
| head_par_err_o | output | 1 | Parity flag of head |
| head_frm_err_o | output | 1 | Framing flag of head |
| head_brk_o | output | 1 | Break flag of head |
| data_ready_o | output | 1 | Queue not empty |
| overrun_o | output | 1 | Character dropped while full |
| fifo_err_o | output | 1 | Flagged character stored |
| trig_hit_o | output | 1 | Count at or above trigger level |
| timeout_o | output | 1 | Idle timeout expired |
| rxrdy_n_o | output | 1 | Active-low receive-ready strobe |

## Verification
The embedded properties are checked on every cycle. They cover the following:
- A full queue keeps its count when a push is dropped, and that drop raises overrun.
- Data ready only rises after a push.
- The timeout and trigger indications never appear with an empty queue.
- A restart always clears the timeout.
- The ready strobe falls one cycle after data is present in mode 0 and is high after two empty cycles.

Some behaviour can only be shown by the directed scenarios. These cover arrival order across a full queue, the exact tick counts for each word length, each trigger level's threshold, the mode-1 latch below the level, and the sticky error bit's release rules.

// File: rtl/rxq_pkg.sv
package rxq_pkg;

    localparam int CHAR_W = 8;
    localparam int TO_W   = 6;
    localparam int LVL_W  = 8;

    typedef struct packed {
        logic              brk;
        logic              frm;
        logic              par;
        logic [CHAR_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        TO_IDLE  = 2'd0,
        TO_RUN   = 2'd1,
        TO_FIRED = 2'd2
    } to_state_t;

    typedef enum logic {
        RDY_OFF = 1'b0,
        RDY_ON  = 1'b1
    } rdy_state_t;

    // Fill threshold for the trigger indication
    function automatic logic [LVL_W-1:0] trig_level(input logic [1:0] sel);
        logic [LVL_W-1:0] lvl;
        unique case (sel)
            2'b00:   lvl = LVL_W'(1);
            2'b01:   lvl = LVL_W'(4);
            2'b10:   lvl = LVL_W'(8);
            default: lvl = LVL_W'(14);
        endcase
        return lvl;
    endfunction

    // 4*(5+code)+12 = 32 + 4*code bit times
    function automatic logic [TO_W-1:0] timeout_ticks(input logic [1:0] wlen);
        return TO_W'(32) + TO_W'({wlen, 2'b00});
    endfunction

endpackage

// File: rtl/rxq_store.sv
module rxq_store
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push_i,
    input  rxq_entry_t    push_ent_i,
    input  logic          pop_i,
    input  logic          flush_i,
    input  logic          single_i,
    output rxq_entry_t    head_o,
    output logic [CW-1:0] count_o,
    output logic          full_o,
    output logic          accept_o,
    output logic          popped_o,
    output logic          reject_o
);

    rxq_entry_t      mem_q [DEPTH];
    logic [AW-1:0]   wr_ptr_q, rd_ptr_q;
    logic [CW-1:0]   count_q;
    logic [CW-1:0]   cap;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign cap      = single_i ? CW'(1) : CW'(DEPTH);
    assign full_o   = (count_q >= cap);
    assign accept_o = push_i && !full_o && !flush_i;
    assign reject_o = push_i && full_o && !flush_i;
    assign popped_o = pop_i && (count_q != '0) && !flush_i;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) mem_q[i] <= '0;
        end else if (accept_o) begin
            mem_q[wr_ptr_q] <= push_ent_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else if (flush_i) begin
            wr_ptr_q <= '0;
            rd_ptr_q <= '0;
            count_q  <= '0;
        end else begin
            if (accept_o) wr_ptr_q <= ptr_inc(wr_ptr_q);
            if (popped_o) rd_ptr_q <= ptr_inc(rd_ptr_q);
            count_q <= count_q + CW'(accept_o) - CW'(popped_o);
        end
    end

    assign count_o = count_q;
    assign head_o  = (count_q != '0) ? mem_q[rd_ptr_q] : '0;

    // R4: a dropped push leaves the stored count unchanged
    p_full_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full_o && !pop_i && !flush_i) |=> (count_o == $past(count_o)));

    // R2: the queue can only leave the empty state through a push
    p_ready_rise_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(count_o != '0) |-> $past(push_i));

endmodule

// File: rtl/rxq_timeout.sv
module rxq_timeout
    import rxq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       enable_i,
    input  logic       nonempty_i,
    input  logic       restart_i,
    input  logic       flush_i,
    input  logic       tick_i,
    input  logic [1:0] wlen_i,
    output logic       timeout_o
);

    to_state_t       state_q, state_d;
    logic [TO_W-1:0] cnt_q, cnt_d;
    logic [TO_W-1:0] limit;

    assign limit = timeout_ticks(wlen_i);

    always_comb begin
        state_d = state_q;
        if (!enable_i || flush_i) begin
            state_d = TO_IDLE;
        end else begin
            unique case (state_q)
                TO_IDLE:  if (nonempty_i) state_d = TO_RUN;
                TO_RUN: begin
                    if (!nonempty_i)                              state_d = TO_IDLE;
                    else if (restart_i)                           state_d = TO_RUN;
                    else if (tick_i && cnt_q == limit - TO_W'(1)) state_d = TO_FIRED;
                end
                TO_FIRED: begin
                    if (!nonempty_i)    state_d = TO_IDLE;
                    else if (restart_i) state_d = TO_RUN;
                end
                default: state_d = TO_IDLE;
            endcase
        end
    end

    always_comb begin
        if (state_d == TO_RUN && state_q == TO_RUN && !restart_i)
            cnt_d = cnt_q + TO_W'(tick_i);
        else
            cnt_d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= TO_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            cnt_q   <= cnt_d;
        end
    end

    always_comb begin
        timeout_o = (state_q == TO_FIRED);
    end

    // R7: an expired timeout never coexists with an empty queue
    p_to_data_r7: assert property (@(posedge clk) disable iff (!rst_n)
        timeout_o |-> nonempty_i);

    // R7: a restart always drops the timeout
    p_to_restart_r7: assert property (@(posedge clk) disable iff (!rst_n)
        restart_i |=> !timeout_o);

endmodule

// File: rtl/rxq_rdy.sv
module rxq_rdy
    import rxq_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic mode1_i,
    input  logic nonempty_i,
    input  logic trig_i,
    input  logic timeout_i,
    output logic rxrdy_n_o
);

    rdy_state_t state_q, state_d;
    logic       go;

    assign go = mode1_i ? (trig_i || timeout_i) : nonempty_i;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            RDY_OFF: if (go)          state_d = RDY_ON;
            RDY_ON:  if (!nonempty_i) state_d = RDY_OFF;
            default: state_d = RDY_OFF;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= RDY_OFF;
        else        state_q <= state_d;
    end

    always_comb begin
        rxrdy_n_o = (state_q != RDY_ON);
    end

    // R9: in mode 0 stored data drives the strobe low one cycle later
    p_rdy_mode0_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!mode1_i && nonempty_i) |=> !rxrdy_n_o);

    // R9/R10: two empty cycles always leave the strobe inactive
    p_rdy_empty_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (!nonempty_i && $past(!nonempty_i)) |-> rxrdy_n_o);

endmodule

// File: rtl/rx_fifo_tmo.sv
module rx_fifo_tmo
    import rxq_pkg::*;
#(
    parameter int DEPTH = 16,
    localparam int CW = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic [CHAR_W-1:0] push_data_i,
    input  logic              push_par_err_i,
    input  logic              push_frm_err_i,
    input  logic              push_brk_i,
    input  logic              stop_mid_i,
    input  logic              bit_tick_i,
    input  logic              rd_data_i,
    input  logic              rd_lsr_i,
    input  logic              fifo_en_i,
    input  logic              fifo_clr_i,
    input  logic [1:0]        trig_sel_i,
    input  logic              dma_mode_i,
    input  logic [1:0]        wlen_i,
    output logic [CHAR_W-1:0] head_data_o,
    output logic              head_par_err_o,
    output logic              head_frm_err_o,
    output logic              head_brk_o,
    output logic              data_ready_o,
    output logic              overrun_o,
    output logic              fifo_err_o,
    output logic              trig_hit_o,
    output logic              timeout_o,
    output logic              rxrdy_n_o
);

    rxq_entry_t       push_ent, head;
    logic [CW-1:0]    count;
    logic             full, accept, popped, reject;
    logic             en_q, flush;
    logic [LVL_W-1:0] level;
    logic             ovr_q, ferr_q;
    logic [CW-1:0]    err_cnt_q, err_cnt_d;
    logic             err_in, err_out;

    // A flush comes from the clear pulse or from any change of queue mode
    assign flush = fifo_clr_i || (fifo_en_i != en_q);

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) en_q <= 1'b0;
        else        en_q <= fifo_en_i;
    end

    assign push_ent = '{brk: push_brk_i, frm: push_frm_err_i,
                        par: push_par_err_i, data: push_data_i};

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .push_i     (push_i),
        .push_ent_i (push_ent),
        .pop_i      (rd_data_i),
        .flush_i    (flush),
        .single_i   (!fifo_en_i),
        .head_o     (head),
        .count_o    (count),
        .full_o     (full),
        .accept_o   (accept),
        .popped_o   (popped),
        .reject_o   (reject)
    );

    assign head_data_o    = head.data;
    assign head_par_err_o = head.par;
    assign head_frm_err_o = head.frm;
    assign head_brk_o     = head.brk;
    assign data_ready_o   = (count != '0);

    assign level      = fifo_en_i ? trig_level(trig_sel_i) : LVL_W'(1);
    assign trig_hit_o = (LVL_W'(count) >= level);

    // Overrun: set by a dropped push, cleared by a status read
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)        ovr_q <= 1'b0;
        else if (reject)   ovr_q <= 1'b1;
        else if (rd_lsr_i) ovr_q <= 1'b0;
    end
    assign overrun_o = ovr_q;

    // Count of stored entries carrying any flag
    assign err_in  = accept && (push_par_err_i || push_frm_err_i || push_brk_i);
    assign err_out = popped && (head.par || head.frm || head.brk);

    always_comb begin
        if (flush) err_cnt_d = '0;
        else       err_cnt_d = err_cnt_q + CW'(err_in) - CW'(err_out);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_cnt_q <= '0;
            ferr_q    <= 1'b0;
        end else begin
            err_cnt_q <= err_cnt_d;
            if (!fifo_en_i || flush)                    ferr_q <= 1'b0;
            else if (err_in)                            ferr_q <= 1'b1;
            else if (rd_lsr_i || err_cnt_d == '0)       ferr_q <= 1'b0;
        end
    end
    assign fifo_err_o = ferr_q;

    rxq_timeout u_timeout (
        .clk        (clk),
        .rst_n      (rst_n),
        .enable_i   (fifo_en_i),
        .nonempty_i (data_ready_o),
        .restart_i  (stop_mid_i || rd_data_i),
        .flush_i    (flush),
        .tick_i     (bit_tick_i),
        .wlen_i     (wlen_i),
        .timeout_o  (timeout_o)
    );

    rxq_rdy u_rdy (
        .clk        (clk),
        .rst_n      (rst_n),
        .mode1_i    (fifo_en_i && dma_mode_i),
        .nonempty_i (data_ready_o),
        .trig_i     (trig_hit_o),
        .timeout_i  (timeout_o),
        .rxrdy_n_o  (rxrdy_n_o)
    );

    // R4: a push into a full queue raises overrun on the next cycle
    p_overrun_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && full && !flush) |=> overrun_o);

    // R4: a status read without a new drop clears overrun
    p_overrun_clr_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_lsr_i && !(push_i && full && !flush)) |=> !overrun_o);

    // R1: the trigger never reports with nothing stored
    p_trig_data_r1: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit_o |-> data_ready_o);

    // R11: the error summary needs queue mode
    p_ferr_mode_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (!fifo_en_i && !$past(fifo_en_i)) |-> !fifo_err_o);

endmodule

// File: tb/test_rx_fifo_tmo.sv
module test_rx_fifo_tmo;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       push_i = 0;
    logic [7:0] push_data_i = 0;
    logic       push_par_err_i = 0, push_frm_err_i = 0, push_brk_i = 0;
    logic       stop_mid_i = 0, bit_tick_i = 0;
    logic       rd_data_i = 0, rd_lsr_i = 0;
    logic       fifo_en_i = 0, fifo_clr_i = 0, dma_mode_i = 0;
    logic [1:0] trig_sel_i = 0, wlen_i = 0;
    logic [7:0] head_data_o;
    logic       head_par_err_o, head_frm_err_o, head_brk_o;
    logic       data_ready_o, overrun_o, fifo_err_o, trig_hit_o, timeout_o, rxrdy_n_o;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    always #2 clk = ~clk;

    rx_fifo_tmo i_rx_fifo_tmo (
        .clk(clk), .rst_n(rst_n),
        .push_i(push_i), .push_data_i(push_data_i),
        .push_par_err_i(push_par_err_i), .push_frm_err_i(push_frm_err_i),
        .push_brk_i(push_brk_i), .stop_mid_i(stop_mid_i), .bit_tick_i(bit_tick_i),
        .rd_data_i(rd_data_i), .rd_lsr_i(rd_lsr_i), .fifo_en_i(fifo_en_i),
        .fifo_clr_i(fifo_clr_i), .trig_sel_i(trig_sel_i), .dma_mode_i(dma_mode_i),
        .wlen_i(wlen_i), .head_data_o(head_data_o), .head_par_err_o(head_par_err_o),
        .head_frm_err_o(head_frm_err_o), .head_brk_o(head_brk_o),
        .data_ready_o(data_ready_o), .overrun_o(overrun_o), .fifo_err_o(fifo_err_o),
        .trig_hit_o(trig_hit_o), .timeout_o(timeout_o), .rxrdy_n_o(rxrdy_n_o)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic push_char(input logic [7:0] d, input logic p, input logic f, input logic b);
        @(negedge clk);
        push_i = 1; push_data_i = d; push_par_err_i = p; push_frm_err_i = f; push_brk_i = b;
        @(negedge clk);
        push_i = 0; push_par_err_i = 0; push_frm_err_i = 0; push_brk_i = 0;
    endtask

    task automatic rd_data();
        @(negedge clk); rd_data_i = 1;
        @(negedge clk); rd_data_i = 0;
    endtask

    task automatic rd_lsr();
        @(negedge clk); rd_lsr_i = 1;
        @(negedge clk); rd_lsr_i = 0;
    endtask

    task automatic flush();
        @(negedge clk); fifo_clr_i = 1;
        @(negedge clk); fifo_clr_i = 0;
    endtask

    task automatic ticks(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk); bit_tick_i = 1;
            @(negedge clk); bit_tick_i = 0;
        end
    endtask

    task automatic t_reset();
        chk("R12 data_ready", data_ready_o, 0);
        chk("R12 overrun", overrun_o, 0);
        chk("R12 fifo_err", fifo_err_o, 0);
        chk("R12 timeout", timeout_o, 0);
        chk("R12 trig", trig_hit_o, 0);
        chk("R12 rxrdy_n", rxrdy_n_o, 1);
    endtask

    task automatic t_order();
        fifo_en_i = 1; trig_sel_i = 2'b00; idle(2);
        push_char(8'h11, 0, 0, 0);
        chk("R2 ready after push", data_ready_o, 1);
        push_char(8'h22, 0, 0, 0);
        push_char(8'h33, 0, 0, 0);
        chk("R3 head first", head_data_o, 8'h11);
        rd_data();
        chk("R3 head second", head_data_o, 8'h22);
        rd_data(); rd_data();
        chk("R2 ready after drain", data_ready_o, 0);
        chk("R3 head zero when empty", head_data_o, 0);
    endtask

    task automatic t_trigger();
        int lv[4] = '{1, 4, 8, 14};
        for (int s = 0; s < 4; s++) begin
            trig_sel_i = 2'(s); flush(); idle(1);
            for (int k = 0; k < lv[s] - 1; k++) push_char(8'(k), 0, 0, 0);
            chk($sformatf("R1 below level sel %0d", s), trig_hit_o, 0);
            push_char(8'hA0, 0, 0, 0);
            chk($sformatf("R1 at level sel %0d", s), trig_hit_o, 1);
            rd_data();
            chk($sformatf("R1 drop below sel %0d", s), trig_hit_o, 0);
        end
    endtask

    task automatic t_overrun();
        trig_sel_i = 2'b11; flush(); idle(1);
        for (int k = 0; k < 16; k++) push_char(8'(k + 8'h40), 0, 0, 0);
        chk("R4 no overrun at full", overrun_o, 0);
        push_char(8'hEE, 0, 0, 0);
        chk("R4 overrun set", overrun_o, 1);
        rd_lsr();
        chk("R4 overrun cleared by status read", overrun_o, 0);
        for (int k = 0; k < 16; k++) begin
            chk("R3 order through full queue", head_data_o, k + 8'h40);
            rd_data();
        end
        chk("R4 dropped char not stored", data_ready_o, 0);
    endtask

    task automatic t_single();
        fifo_en_i = 0; idle(2);
        push_char(8'h5A, 0, 0, 0);
        chk("R1 level one without queue", trig_hit_o, 1);
        push_char(8'hA5, 0, 0, 0);
        chk("R5 second push overruns", overrun_o, 1);
        chk("R5 head keeps first", head_data_o, 8'h5A);
        rd_data();
        chk("R5 empty after one read", data_ready_o, 0);
        rd_lsr();
    endtask

    task automatic t_clear();
        fifo_en_i = 1; idle(2);
        push_char(8'h01, 0, 0, 0); push_char(8'h02, 0, 0, 0); push_char(8'h03, 0, 0, 0);
        flush();
        chk("R8 clear empties", data_ready_o, 0);
        push_char(8'h77, 0, 0, 0);
        chk("R8 pointers reset", head_data_o, 8'h77);
        fifo_en_i = 0; idle(2);
        chk("R8 mode change empties", data_ready_o, 0);
        fifo_en_i = 1; idle(2);
    endtask

    task automatic t_timeout();
        trig_sel_i = 2'b11; wlen_i = 2'b10; flush(); idle(1);
        ticks(50);
        chk("R7 no timeout when empty", timeout_o, 0);
        push_char(8'hC1, 0, 0, 0); push_char(8'hC2, 0, 0, 0); idle(2);
        ticks(39);
        chk("R6 not yet at 39 ticks", timeout_o, 0);
        ticks(1);
        chk("R6 fires at 40 ticks", timeout_o, 1);
        @(negedge clk); stop_mid_i = 1; @(negedge clk); stop_mid_i = 0;
        chk("R7 stop middle restarts", timeout_o, 0);
        ticks(40);
        chk("R6 fires again", timeout_o, 1);
        wlen_i = 2'b00;
        rd_data();
        chk("R7 data read restarts", timeout_o, 0);
        ticks(31);
        chk("R6 five-bit not at 31", timeout_o, 0);
        ticks(1);
        chk("R6 five-bit fires at 32", timeout_o, 1);
        fifo_en_i = 0; idle(2);
        chk("R7 no timeout without queue", timeout_o, 0);
        fifo_en_i = 1; idle(2);
    endtask

    task automatic t_rdy0();
        dma_mode_i = 0; flush(); idle(1);
        chk("R9 idle high", rxrdy_n_o, 1);
        push_char(8'h10, 0, 0, 0); idle(1);
        chk("R9 low with data", rxrdy_n_o, 0);
        rd_data(); idle(1);
        chk("R9 high when empty", rxrdy_n_o, 1);
    endtask

    task automatic t_rdy1();
        dma_mode_i = 1; trig_sel_i = 2'b01; wlen_i = 2'b00; flush(); idle(1);
        for (int k = 0; k < 3; k++) push_char(8'(k), 0, 0, 0);
        idle(1);
        chk("R10 high below level", rxrdy_n_o, 1);
        push_char(8'h03, 0, 0, 0); idle(1);
        chk("R10 low at level", rxrdy_n_o, 0);
        rd_data(); idle(1);
        chk("R10 stays low below level", rxrdy_n_o, 0);
        rd_data(); rd_data(); rd_data(); idle(1);
        chk("R10 high when empty", rxrdy_n_o, 1);
        push_char(8'h55, 0, 0, 0); idle(2);
        ticks(32); idle(1);
        chk("R10 low on timeout", rxrdy_n_o, 0);
        rd_data(); idle(1);
        chk("R10 high after drain", rxrdy_n_o, 1);
        dma_mode_i = 0;
    endtask

    task automatic t_err();
        trig_sel_i = 2'b11; flush(); idle(1);
        push_char(8'h10, 0, 0, 0);
        push_char(8'h20, 1, 0, 0);
        chk("R11 summary set", fifo_err_o, 1);
        chk("R3 head flag clean", head_par_err_o, 0);
        rd_data();
        chk("R3 head parity flag", head_par_err_o, 1);
        rd_lsr();
        chk("R11 cleared by status read", fifo_err_o, 0);
        push_char(8'h30, 0, 1, 1);
        chk("R11 set by new flagged", fifo_err_o, 1);
        rd_data();
        chk("R11 held while flagged stored", fifo_err_o, 1);
        chk("R3 head break flag", head_brk_o, 1);
        rd_data();
        chk("R11 clear when none stored", fifo_err_o, 0);
    endtask

    initial begin
        idle(3);
        t_reset();
        rst_n = 1;
        idle(2);
        t_reset();
        t_order();
        t_trigger();
        t_overrun();
        t_single();
        t_clear();
        t_timeout();
        t_rdy0();
        t_rdy1();
        t_err();
        done = 1;
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_run++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

endmodule